// File: doc/BRIEF.md
# Conversion Result Register Bank

This block stores the latest conversion result of each of eight analog channels and hands the results to a host one byte at a time. Each channel occupies two byte addresses. The address is `{channel, half}`. Half 0 is the high byte and half 1 is the low byte. A converter writes a finished result through a one-cycle result port. The host reads the byte under an internal read pointer. After each read the pointer moves by itself. Consecutive reads therefore walk through the channels that the active-channel mask enables, without the host re-addressing.

Two result formats are supported. In narrow (8-bit) mode only the low byte of each channel is visible, and every read jumps to the next enabled channel. In wide (10-bit) mode the high byte carries the two upper result bits together with two per-channel flags: "fresh data" and "overrun". A high-byte read steps to the same channel's low byte. A low-byte read steps to the next enabled channel's high byte.

The flags are cleared by reading the channel or by a flag-clear strobe. The flag-clear strobe stands for a write to the mode or channel-select registers. A pointer-load strobe stands for a write to the start register. It places the pointer and never touches the flags.

Top module: `adc_result_bank`

## Requirements
- R1: After reset the read pointer is 0, every result is 0 and every flag is clear, so `rd_data` reads 0x00.
- R2: With `wide_mode`=0, `rd_data` is bits 7..0 of the pointed channel's result whatever the pointer's bit 0 is, and no flag appears in it.
- R3: With `wide_mode`=1 and pointer bit 0 = 0 (high byte), `rd_data` is {fresh flag in bit 7, overrun flag in bit 6, zeros in bits 5..2, result bits 9..8 in bits 1..0}. With pointer bit 0 = 1 (low byte), `rd_data` is result bits 7..0.
- R4: In wide mode, a read of a high byte moves the pointer to the low byte of the same channel on the next cycle.
- R5: A low-byte read in wide mode, or any read in narrow mode, moves the pointer to the next channel above the current one that is set in `active_mask`. The search wraps from channel 7 to channel 0, and the current channel is found last. The pointer lands on the high byte in wide mode and on the low byte in narrow mode.
- R6: When `active_mask` is 0, a read that would move the pointer under R5 leaves the pointer unchanged.
- R7: `ptr_load` sets the pointer to `ptr_load_addr` on the next cycle and takes priority over any advance from a read in the same cycle.
- R8: `conv_valid` stores `conv_result` into channel `conv_ch` and sets that channel's fresh flag.
- R9: A read of either byte of a channel clears that channel's fresh and overrun flags.
- R10: `flag_clr` clears every fresh and overrun flag. `ptr_load` clears no flag.
- R11: `conv_valid` on a channel whose fresh flag is set sets its overrun flag when `track_ovr`=1. With `track_ovr`=0 no overrun flag is set. An overrun flag is never set while the channel's fresh flag is clear.
- R12: A result write and a read (or `flag_clr`) that hit the same channel in the same cycle leave the new result stored, the fresh flag set and the overrun flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_ch | input | 3 | Channel of the finished conversion |
| conv_result | input | 10 | Conversion result, right-justified |
| active_mask | input | 8 | Enabled channels for pointer advance, bit n = channel n |
| wide_mode | input | 1 | 1 = 10-bit format, 0 = 8-bit format |
| track_ovr | input | 1 | 1 = overrun detection active (single or continuous scan) |
| flag_clr | input | 1 | Mode or channel-select register write: clear all flags |
| ptr_load | input | 1 | Start register write: load the read pointer |
| ptr_load_addr | input | 4 | Pointer value to load, {channel, half} |
| rd_en | input | 1 | Host consumes the byte on `rd_data` this cycle |
| rd_data | output | 8 | Byte at the current pointer |
| rd_addr | output | 4 | Current read pointer, {channel, half} |

## Verification
The bench builds the block with its default parameters: eight channels and a 10-bit result. With that size, random masks often come out empty or with a single channel enabled. The wrap from channel 7 to channel 0, the self-wrap and the stalled pointer are therefore reached many times, not only in the directed cases. The three-bit channel field keeps same-channel collisions frequent: a result write landing on the channel being read or cleared, and repeated writes that build overruns. This exercises the flag priority rules under both format modes.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  localparam int RB_BYTE_W = 8;
  typedef logic [RB_BYTE_W-1:0] rb_byte_t;
  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} rb_half_e;
endpackage

// File: rtl/adc_rb_store.sv
module adc_rb_store #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_valid,
  input  logic [CH_W-1:0]  conv_ch,
  input  logic [RES_W-1:0] conv_result,
  input  logic             track_ovr,
  input  logic             flag_clr,
  input  logic             rd_fire,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] res_q [NUM_CH],
  output logic [NUM_CH-1:0] dv_vec,
  output logic [NUM_CH-1:0] ov_vec
);
  // Overrun after a write: an existing overrun persists, a new one needs the
  // fresh flag still set and tracking on; any clear that cycle cancels it.
  function automatic logic ovr_next(input logic ov_old, input logic dv_old,
                                    input logic trk, input logic wipe);
    return (ov_old | (trk & dv_old)) & ~wipe;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_wr;
    logic hit_rd;
    logic wipe;
    assign hit_wr = conv_valid && (conv_ch == CH_W'(c));
    assign hit_rd = rd_fire && (rd_ch == CH_W'(c));
    assign wipe   = hit_rd || flag_clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[c]  <= '0;
        dv_vec[c] <= 1'b0;
        ov_vec[c] <= 1'b0;
      end else if (hit_wr) begin
        res_q[c]  <= conv_result;
        dv_vec[c] <= 1'b1;
        ov_vec[c] <= ovr_next(ov_vec[c], dv_vec[c], track_ovr, wipe);
      end else if (wipe) begin
        dv_vec[c] <= 1'b0;
        ov_vec[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_rb_ptr.sv
module adc_rb_ptr
  import adc_rb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              wide,
  input  logic [NUM_CH-1:0] mask,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_load_addr,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              step_in_ch,
  output logic              step_to_ch
);
  // Next enabled channel strictly above cur, wrapping; cur itself is last.
  function automatic logic [CH_W-1:0] seek_next(input logic [CH_W-1:0] cur,
                                                input logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] pick;
    logic found;
    int idx;
    pick  = cur;
    found = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = (int'(cur) + k) % NUM_CH;
      if (!found && m[idx[CH_W-1:0]]) begin
        pick  = idx[CH_W-1:0];
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  logic [CH_W-1:0]   cur_ch;
  rb_half_e          cur_half;
  logic [ADDR_W-1:0] ptr_d;

  assign cur_ch   = ptr_q[ADDR_W-1:1];
  assign cur_half = rb_half_e'(ptr_q[0]);

  assign step_in_ch = rd_fire && !ptr_load && wide && (cur_half == HALF_HI);
  assign step_to_ch = rd_fire && !ptr_load && !step_in_ch && (|mask);

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load)        ptr_d = ptr_load_addr;
    else if (step_in_ch) ptr_d = {cur_ch, HALF_LO};
    else if (step_to_ch) ptr_d = {seek_next(cur_ch, mask), wide ? HALF_HI : HALF_LO};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/adc_rb_rdmux.sv
module adc_rb_rdmux
  import adc_rb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1,
  localparam int HI_W  = RES_W - RB_BYTE_W,
  localparam int PAD_W = RB_BYTE_W - 2 - HI_W
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic              wide,
  input  logic [RES_W-1:0]  res_q [NUM_CH],
  input  logic [NUM_CH-1:0] dv_vec,
  input  logic [NUM_CH-1:0] ov_vec,
  output rb_byte_t          rd_data
);
  function automatic rb_byte_t pack_hi(input logic [RES_W-1:0] r,
                                       input logic dv, input logic ov);
    return {dv, ov, {PAD_W{1'b0}}, r[RES_W-1:RB_BYTE_W]};
  endfunction

  function automatic rb_byte_t pack_lo(input logic [RES_W-1:0] r);
    return r[RB_BYTE_W-1:0];
  endfunction

  logic [CH_W-1:0]  sel_ch;
  logic [RES_W-1:0] sel_res;
  rb_half_e         sel_half;

  assign sel_ch   = ptr[ADDR_W-1:1];
  assign sel_half = rb_half_e'(ptr[0]);
  assign sel_res  = res_q[sel_ch];

  always_comb begin
    if (wide && sel_half == HALF_HI)
      rd_data = pack_hi(sel_res, dv_vec[sel_ch], ov_vec[sel_ch]);
    else
      rd_data = pack_lo(sel_res);
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_rb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [NUM_CH-1:0] active_mask,
  input  logic              wide_mode,
  input  logic              track_ovr,
  input  logic              flag_clr,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_load_addr,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr
);
  // Named internal events for the bound checker.
  logic [CH_W-1:0]   rd_ch;
  logic [RES_W-1:0]  res_q [NUM_CH];
  logic [NUM_CH-1:0] dv_vec;
  logic [NUM_CH-1:0] ov_vec;
  logic              step_in_ch;
  logic              step_to_ch;
  rb_byte_t          byte_out;

  assign rd_ch   = rd_addr[ADDR_W-1:1];
  assign rd_data = byte_out;

  adc_rb_store #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .conv_valid(conv_valid), .conv_ch(conv_ch), .conv_result(conv_result),
    .track_ovr(track_ovr), .flag_clr(flag_clr),
    .rd_fire(rd_en), .rd_ch(rd_ch),
    .res_q(res_q), .dv_vec(dv_vec), .ov_vec(ov_vec)
  );

  adc_rb_ptr #(.NUM_CH(NUM_CH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .rd_fire(rd_en), .wide(wide_mode), .mask(active_mask),
    .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
    .ptr_q(rd_addr), .step_in_ch(step_in_ch), .step_to_ch(step_to_ch)
  );

  adc_rb_rdmux #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_mux (
    .ptr(rd_addr), .wide(wide_mode), .res_q(res_q),
    .dv_vec(dv_vec), .ov_vec(ov_vec), .rd_data(byte_out)
  );
endmodule

// File: rtl/adc_rb_checker.sv
module adc_rb_checker #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_valid,
  input logic [CH_W-1:0]   conv_ch,
  input logic [NUM_CH-1:0] active_mask,
  input logic              wide_mode,
  input logic              track_ovr,
  input logic              flag_clr,
  input logic              ptr_load,
  input logic [ADDR_W-1:0] ptr_load_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NUM_CH-1:0] dv_vec,
  input logic [NUM_CH-1:0] ov_vec
);
  logic [CH_W-1:0] cur_ch;
  assign cur_ch = rd_addr[ADDR_W-1:1];

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> rd_addr == $past(ptr_load_addr));

  assert_hi_to_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ptr_load && wide_mode && !rd_addr[0]
    |=> rd_addr == {$past(cur_ch), 1'b1});

  assert_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ptr_load && active_mask == '0 && (!wide_mode || rd_addr[0])
    |=> $stable(rd_addr));

  assert_set_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> dv_vec[$past(conv_ch)]);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !(conv_valid && conv_ch == cur_ch)
    |=> !dv_vec[$past(cur_ch)] && !ov_vec[$past(cur_ch)]);

  assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !conv_valid |=> dv_vec == '0 && ov_vec == '0);

  assert_load_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load && !flag_clr && !rd_en |=> (dv_vec & $past(dv_vec)) == $past(dv_vec));

  assert_ovr_needs_fresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_vec & ~dv_vec) == '0);

  assert_no_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !track_ovr && !ov_vec[conv_ch] |=> !ov_vec[$past(conv_ch)]);

  assert_collide_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && ((rd_en && conv_ch == cur_ch) || flag_clr)
    |=> dv_vec[$past(conv_ch)] && !ov_vec[$past(conv_ch)]);
endmodule

bind adc_result_bank adc_rb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
  .active_mask(active_mask), .wide_mode(wide_mode), .track_ovr(track_ovr),
  .flag_clr(flag_clr), .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .dv_vec(dv_vec), .ov_vec(ov_vec)
);

// File: tb/sim_adc_result_bank.sv
`timescale 1ns/1ps
module sim_adc_result_bank;
  localparam int NUM_CH = 8;
  localparam int RES_W  = 10;
  localparam int CH_W   = 3;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              conv_valid;
  logic [CH_W-1:0]   conv_ch;
  logic [RES_W-1:0]  conv_result;
  logic [NUM_CH-1:0] active_mask;
  logic              wide_mode, track_ovr, flag_clr, ptr_load, rd_en;
  logic [ADDR_W-1:0] ptr_load_addr;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] rd_addr;

  adc_result_bank u0 (.*);

  int n_vec = 0;
  int n_bad = 0;

  // Bench-side model of the register bank.
  logic [RES_W-1:0]  m_res [NUM_CH];
  logic              m_dv  [NUM_CH];
  logic              m_ov  [NUM_CH];
  logic [ADDR_W-1:0] m_ptr;

  function automatic logic [7:0] exp_byte();
    int ch;
    ch = int'(m_ptr) / 2;
    if (!wide_mode) return m_res[ch][7:0];                 // R2
    if (m_ptr % 2 == 0) return {m_dv[ch], m_ov[ch], 4'b0000, m_res[ch][9:8]}; // R3
    return m_res[ch][7:0];
  endfunction

  function automatic int next_on(int cur);
    for (int k = 1; k <= NUM_CH; k++)
      if (active_mask[(cur + k) % NUM_CH]) return (cur + k) % NUM_CH;
    return -1;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NUM_CH; c++) begin
      m_res[c] = '0; m_dv[c] = 1'b0; m_ov[c] = 1'b0;
    end
    m_ptr = '0;
  endtask

  task automatic model_step();
    int rc, nx;
    logic ov_w;
    rc   = int'(m_ptr) / 2;
    ov_w = m_ov[conv_ch] | (track_ovr & m_dv[conv_ch]);
    if (flag_clr)
      for (int c = 0; c < NUM_CH; c++) begin m_dv[c] = 1'b0; m_ov[c] = 1'b0; end
    if (rd_en) begin m_dv[rc] = 1'b0; m_ov[rc] = 1'b0; end
    if (conv_valid) begin
      m_res[conv_ch] = conv_result;
      m_dv[conv_ch]  = 1'b1;
      m_ov[conv_ch]  = ov_w && !flag_clr && !(rd_en && rc == int'(conv_ch));
    end
    if (ptr_load) m_ptr = ptr_load_addr;
    else if (rd_en) begin
      if (wide_mode && m_ptr[0] == 1'b0) m_ptr = m_ptr | 4'd1;
      else begin
        nx = next_on(rc);
        if (nx >= 0) m_ptr = ADDR_W'(nx * 2 + (wide_mode ? 0 : 1));
      end
    end
  endtask

  task automatic check(input string tag);
    logic [7:0] eb;
    eb = exp_byte();
    n_vec++;
    if (rd_addr !== m_ptr) begin
      n_bad++;
      $display("FAIL %s pointer: actual %h expected %h", tag, rd_addr, m_ptr);
    end
    n_vec++;
    if (rd_data !== eb) begin
      n_bad++;
      $display("FAIL %s data: actual %h expected %h", tag, rd_data, eb);
    end
  endtask

  task automatic idle();
    conv_valid = 1'b0; flag_clr = 1'b0; ptr_load = 1'b0; rd_en = 1'b0;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
    idle();
  endtask

  task automatic conv(input int ch, input int val);
    conv_valid = 1'b1; conv_ch = CH_W'(ch); conv_result = RES_W'(val);
  endtask

  task automatic load(input int a);
    ptr_load = 1'b1; ptr_load_addr = ADDR_W'(a);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd20240611);
    rst_n = 1'b0; idle(); conv_ch = '0; conv_result = '0; active_mask = '1;
    wide_mode = 1'b1; track_ovr = 1'b1; ptr_load_addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R8 / R3: one conversion on channel 0, wide high byte
    conv(0, 10'h2A5); tick("R8 store and fresh flag");
    conv(0, 10'h1C3); tick("R11 overrun with tracking");
    rd_en = 1'b1;     tick("R4 high to low step");
    check("R9 flags cleared by high read");
    rd_en = 1'b1;     tick("R5 low to next channel high");

    // R10: start write keeps flags, flag clear wipes them
    conv(3, 10'h3FF); tick("R8 channel 3");
    load(6);          tick("R10 load keeps fresh flag");
    load(1);          tick("R7 load");
    conv(5, 10'h155); tick("R8 channel 5");
    load(10);         tick("R7 load ch5 high");
    flag_clr = 1'b1;  tick("R10 flag clear");

    // R7 priority over advance
    rd_en = 1'b1; load(12); tick("R7 load beats advance");

    // R5 wrap to channel 0 and self-wrap
    active_mask = 8'b0000_0001;
    load(15);     tick("R7 load ch7 low");
    rd_en = 1'b1; tick("R5 wrap 7 to 0");
    rd_en = 1'b1; tick("R4 ch0 high to low");
    rd_en = 1'b1; tick("R5 self wrap");

    // R6 empty mask
    active_mask = '0;
    load(9);      tick("R7 load");
    rd_en = 1'b1; tick("R6 empty mask holds");
    wide_mode = 1'b0;
    rd_en = 1'b1; tick("R6 empty mask narrow");

    // R2 narrow walk
    active_mask = 8'b0010_0100;
    conv(2, 10'h3E7); load(0); tick("R8 load ch0");
    rd_en = 1'b1; tick("R2 narrow to ch2 low");
    rd_en = 1'b1; tick("R2 narrow to ch5 low");
    rd_en = 1'b1; tick("R5 narrow wrap to ch2");

    // R12 collision on channel 4
    wide_mode = 1'b1; active_mask = '1;
    conv(4, 10'h001); load(8); tick("R8 ch4");
    conv(4, 10'h2F0); rd_en = 1'b1; tick("R12 write beats read");
    load(8); tick("R12 fresh set overrun clear");
    conv(4, 10'h0AA); flag_clr = 1'b1; tick("R12 write beats clear");

    // R11 no tracking
    track_ovr = 1'b0;
    conv(6, 10'h100); tick("R11 first write");
    conv(6, 10'h101); load(12); tick("R11 untracked second write");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 40) conv($urandom_range(7), $urandom_range(1023));
      rd_en     = ($urandom_range(99) < 50);
      flag_clr  = ($urandom_range(99) < 4);
      track_ovr = ($urandom_range(99) < 70);
      if ($urandom_range(99) < 8) load($urandom_range(15));
      if ($urandom_range(99) < 5) begin
        case ($urandom_range(3))
          0: active_mask = '0;
          1: active_mask = NUM_CH'(1) << $urandom_range(7);
          default: active_mask = NUM_CH'($urandom_range(255));
        endcase
      end
      if ($urandom_range(99) < 3) wide_mode = ~wide_mode;
      tick("random R2/R3/R5/R6/R9/R11/R12");
    end
    finish_run();
  end
endmodule